// File: doc/BRIEF.md
# NAND Flash Bus Cycle Sequencer

This block turns single-beat host requests into the strobe waveforms of an 8-bit parallel NAND flash device. A request is a command byte, an address byte, or a data transfer that can be a read or a write. For each accepted request the block runs one bus cycle with three phases: setup, strobe width and hold. An optional ready-wait phase can follow the hold phase before the block accepts the next request. The block drives the command-latch and address-latch enables, the active-low write and read strobes, the active-low chip enable, and the outgoing data byte with its drive enable.

The length of each phase comes from a 32-bit timing word that is held outside the block. Read cycles and write cycles each use their own group of four 4-bit fields. The block captures the word when it accepts a request, so a change to the word during a cycle has no effect on that cycle. The device ready/busy pin passes through a two-flop synchroniser and is reported as a status level. A configuration input can hold chip enable asserted between cycles. A synchronous soft reset aborts any cycle that is in progress.

Top module: `nandSeq`

## Requirements
- R1: After reset, reqReady is 1, nandWeN, nandReN and nandCeN are 1, nandCle and nandAle are 0, and rspValid is 0.
- R2: reqKind 0 is a command: nandCle is 1 for the whole cycle. reqKind 1 is an address: nandAle is 1 for the whole cycle. reqKind 2 or 3 is data, and neither latch enable is asserted. Command and address requests are always writes, whatever reqWrite is. Both latch enables are 0 while the block is idle.
- R3: In a write cycle, nandWeN stays high for S+1 cycles after the accepting edge and is then low for W+1 cycles. S is timingWord[19:16] and W is timingWord[27:24].
- R4: In a read cycle (data kind with reqWrite 0), nandReN stays high for S+1 cycles after the accepting edge and is then low for W+1 cycles. S is timingWord[3:0] and W is timingWord[11:8].
- R5: After the strobe, the block stays busy for H+1+2*D more cycles and then raises reqReady again. For a read, H is timingWord[7:4] and D is timingWord[15:12]. For a write, H is timingWord[23:20] and D is timingWord[31:28]. The field group of the other direction has no effect.
- R6: A read returns the byte present on nandDin at the last clock of the low strobe on rspData. rspValid pulses for exactly one cycle, in the first cycle in which reqReady is 1 again. Writes produce no rspValid.
- R7: During a write cycle, nandDout carries the request byte and does not change while nandWeN is low, and nandDoe is 1. nandDoe is 0 during read cycles.
- R8: The timing word is captured on the accepting edge. Changing timingWord during a cycle does not change that cycle's phase lengths.
- R9: nandCeN is 0 whenever a cycle is in progress. While the block is idle, nandCeN is the inverse of forceCeLow.
- R10: devReady shows the level on nandRb (1 = device ready) after two rising clock edges.
- R11: A clock edge with softRst at 1 returns the block to idle. All strobes go to their inactive levels and nandDoe goes to 0. No response is produced for the aborted cycle.
- R12: nandWeN and nandReN are never low together, and nandCle and nandAle are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| softRst | input | 1 | Synchronous abort back to idle |
| timingWord | input | 32 | Phase length fields for reads and writes |
| forceCeLow | input | 1 | Hold chip enable asserted while idle |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle; the request is taken on this edge |
| reqKind | input | 2 | 0 command, 1 address, 2/3 data |
| reqWrite | input | 1 | Data direction for data requests (1 = write) |
| reqData | input | 8 | Byte to write |
| rspValid | output | 1 | Read byte available (one-cycle pulse) |
| rspData | output | 8 | Read byte |
| devReady | output | 1 | Synchronised device-ready level |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandWeN | output | 1 | Write strobe, active low |
| nandReN | output | 1 | Read strobe, active low |
| nandCeN | output | 1 | Chip enable, active low |
| nandDout | output | 8 | Outgoing data byte |
| nandDoe | output | 1 | Data output drive enable |
| nandDin | input | 8 | Incoming data byte |
| nandRb | input | 1 | Device ready/busy pin (1 = ready) |

## Verification
Two functions can fall in the same cycle. The first is the timing-word capture on the accepting edge. The second is a change of timingWord by the host immediately afterwards. The bench provokes this on every table vector: in the first cycle after acceptance, it replaces the timing word with its bitwise inverse. It then judges the measured setup, strobe and tail lengths only against the original fields. A second collision is a soft reset that lands in the middle of a read strobe. The bench judges this by the inactive strobes on the next cycle and by the absence of any response pulse.

// File: rtl/nandSeqPkg.sv
package nandSeqPkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETUP = 3'd1,
    PH_PULSE = 3'd2,
    PH_HOLD  = 3'd3,
    PH_WAIT  = 3'd4
  } phase_e;

  // Strobes from the sequencer control to the datapath
  typedef struct packed {
    logic accept;   // request taken on this edge
    logic busy;     // a bus cycle is in progress
    logic strobe;   // width phase: WE# or RE# asserted
    logic capture;  // last clock of the width phase
    logic finish;   // last clock of the whole cycle
  } seqCtl_t;

  localparam logic [1:0] KIND_CMD  = 2'd0;
  localparam logic [1:0] KIND_ADDR = 2'd1;
endpackage

// File: rtl/nandSeqCtrl.sv
module nandSeqCtrl
  import nandSeqPkg::*;
#(
  parameter int FIELD_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               softRst,
  input  logic               reqValid,
  input  logic               reqIsWrite,
  input  logic [8*FIELD_W-1:0] timingWord,
  output logic               reqReady,
  output seqCtl_t            ctl
);
  localparam int TW_W     = 8 * FIELD_W;
  localparam int GRP_W    = 4 * FIELD_W;
  localparam int CNT_W    = FIELD_W + 1;
  localparam int SET_OFS  = 0;
  localparam int HOLD_OFS = FIELD_W;
  localparam int WID_OFS  = 2 * FIELD_W;
  localparam int WAIT_OFS = 3 * FIELD_W;

  phase_e             phase;
  logic [CNT_W-1:0]   cnt;
  logic [FIELD_W-1:0] setupL, widthL, holdL, waitL;
  logic [GRP_W-1:0]   grp;
  logic [CNT_W-1:0]   phaseLim;
  logic               lastCyc;

  // Pick the field group for the direction of the incoming request
  assign grp = reqIsWrite ? timingWord[TW_W-1:GRP_W] : timingWord[GRP_W-1:0];

  always_comb begin
    unique case (phase)
      PH_SETUP: phaseLim = {1'b0, setupL};
      PH_PULSE: phaseLim = {1'b0, widthL};
      PH_HOLD:  phaseLim = {1'b0, holdL};
      PH_WAIT:  phaseLim = {waitL, 1'b0} - CNT_W'(1);
      default:  phaseLim = '0;
    endcase
  end

  assign lastCyc = (cnt == phaseLim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      setupL <= '0;
      widthL <= '0;
      holdL  <= '0;
      waitL  <= '0;
    end else if (softRst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          cnt <= '0;
          if (reqValid) begin
            phase  <= PH_SETUP;
            setupL <= grp[SET_OFS  +: FIELD_W];
            widthL <= grp[WID_OFS  +: FIELD_W];
            holdL  <= grp[HOLD_OFS +: FIELD_W];
            waitL  <= grp[WAIT_OFS +: FIELD_W];
          end
        end
        PH_SETUP, PH_PULSE, PH_HOLD, PH_WAIT: begin
          if (!lastCyc) begin
            cnt <= cnt + CNT_W'(1);
          end else begin
            cnt <= '0;
            unique case (phase)
              PH_SETUP: phase <= PH_PULSE;
              PH_PULSE: phase <= PH_HOLD;
              PH_HOLD:  phase <= (waitL != '0) ? PH_WAIT : PH_IDLE;
              default:  phase <= PH_IDLE;
            endcase
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign reqReady    = (phase == PH_IDLE);
  assign ctl.accept  = reqReady && reqValid && !softRst;
  assign ctl.busy    = !reqReady;
  assign ctl.strobe  = (phase == PH_PULSE);
  assign ctl.capture = (phase == PH_PULSE) && lastCyc;
  assign ctl.finish  = lastCyc &&
                       (((phase == PH_HOLD) && (waitL == '0)) || (phase == PH_WAIT));
endmodule

// File: rtl/nandSeqPath.sv
module nandSeqPath
  import nandSeqPkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              softRst,
  input  seqCtl_t           ctl,
  input  logic [1:0]        reqKind,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqData,
  input  logic              forceCeLow,
  input  logic [DATA_W-1:0] nandDin,
  input  logic              nandRb,
  output logic              reqIsWrite,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              devReady,
  output logic              nandCle,
  output logic              nandAle,
  output logic              nandWeN,
  output logic              nandReN,
  output logic              nandCeN,
  output logic [DATA_W-1:0] nandDout,
  output logic              nandDoe
);
  logic              cleL, aleL, wrL;
  logic [DATA_W-1:0] doutL;
  logic [SYNC_STAGES-1:0] rbSync;

  // Command and address requests always write
  assign reqIsWrite = (reqKind == KIND_CMD) || (reqKind == KIND_ADDR) || reqWrite;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cleL  <= 1'b0;
      aleL  <= 1'b0;
      wrL   <= 1'b0;
      doutL <= '0;
    end else if (ctl.accept) begin
      cleL  <= (reqKind == KIND_CMD);
      aleL  <= (reqKind == KIND_ADDR);
      wrL   <= reqIsWrite;
      doutL <= reqData;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rspData  <= '0;
      rspValid <= 1'b0;
    end else begin
      if (ctl.capture && !wrL && !softRst) begin
        rspData <= nandDin;
      end
      rspValid <= ctl.finish && !wrL && !softRst;
    end
  end

  // Ready pin synchroniser
  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rbSync[i] <= 1'b0;
        end else if (i == 0) begin
          rbSync[i] <= nandRb;
        end else begin
          rbSync[i] <= rbSync[(i == 0) ? 0 : i-1];
        end
      end
    end
  endgenerate

  assign devReady = rbSync[SYNC_STAGES-1];
  assign nandCle  = ctl.busy && cleL;
  assign nandAle  = ctl.busy && aleL;
  assign nandWeN  = !(ctl.strobe && wrL);
  assign nandReN  = !(ctl.strobe && !wrL);
  assign nandCeN  = !(ctl.busy || forceCeLow);
  assign nandDoe  = ctl.busy && wrL;
  assign nandDout = doutL;
endmodule

// File: rtl/nandSeq.sv
module nandSeq
  import nandSeqPkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int FIELD_W     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 softRst,
  input  logic [8*FIELD_W-1:0] timingWord,
  input  logic                 forceCeLow,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic [1:0]           reqKind,
  input  logic                 reqWrite,
  input  logic [DATA_W-1:0]    reqData,
  output logic                 rspValid,
  output logic [DATA_W-1:0]    rspData,
  output logic                 devReady,
  output logic                 nandCle,
  output logic                 nandAle,
  output logic                 nandWeN,
  output logic                 nandReN,
  output logic                 nandCeN,
  output logic [DATA_W-1:0]    nandDout,
  output logic                 nandDoe,
  input  logic [DATA_W-1:0]    nandDin,
  input  logic                 nandRb
);
  seqCtl_t ctl;
  logic    reqIsWrite;

  nandSeqCtrl #(.FIELD_W(FIELD_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .softRst    (softRst),
    .reqValid   (reqValid),
    .reqIsWrite (reqIsWrite),
    .timingWord (timingWord),
    .reqReady   (reqReady),
    .ctl        (ctl)
  );

  nandSeqPath #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_path (
    .clk        (clk),
    .rst_n      (rst_n),
    .softRst    (softRst),
    .ctl        (ctl),
    .reqKind    (reqKind),
    .reqWrite   (reqWrite),
    .reqData    (reqData),
    .forceCeLow (forceCeLow),
    .nandDin    (nandDin),
    .nandRb     (nandRb),
    .reqIsWrite (reqIsWrite),
    .rspValid   (rspValid),
    .rspData    (rspData),
    .devReady   (devReady),
    .nandCle    (nandCle),
    .nandAle    (nandAle),
    .nandWeN    (nandWeN),
    .nandReN    (nandReN),
    .nandCeN    (nandCeN),
    .nandDout   (nandDout),
    .nandDoe    (nandDoe)
  );
endmodule

// File: rtl/nandSeqChk.sv
module nandSeqChk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              softRst,
  input logic              reqReady,
  input logic              rspValid,
  input logic              nandCle,
  input logic              nandAle,
  input logic              nandWeN,
  input logic              nandReN,
  input logic              nandCeN,
  input logic [DATA_W-1:0] nandDout
);
  // R12
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nandWeN && !nandReN));

  // R12
  latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(nandCle && nandAle));

  // R2
  idle_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reqReady |-> (!nandCle && !nandAle));

  // R9
  ce_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reqReady |-> !nandCeN);

  // R6
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid |=> !rspValid);

  // R7
  dout_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!nandWeN && !$past(nandWeN)) |-> $stable(nandDout));

  // R11
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    softRst |=> (reqReady && nandWeN && nandReN && !rspValid));
endmodule

bind nandSeq nandSeqChk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .softRst  (softRst),
  .reqReady (reqReady),
  .rspValid (rspValid),
  .nandCle  (nandCle),
  .nandAle  (nandAle),
  .nandWeN  (nandWeN),
  .nandReN  (nandReN),
  .nandCeN  (nandCeN),
  .nandDout (nandDout)
);

// File: tb/tb_nandSeq.sv
`timescale 1ns/1ps
module tb_nandSeq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        softRst = 1'b0;
  logic [31:0] timingWord = '0;
  logic        forceCeLow = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [1:0]  reqKind = '0;
  logic        reqWrite = 1'b0;
  logic [7:0]  reqData = '0;
  logic        rspValid;
  logic [7:0]  rspData;
  logic        devReady;
  logic        nandCle, nandAle, nandWeN, nandReN, nandCeN, nandDoe;
  logic [7:0]  nandDout;
  logic [7:0]  nandDin = '0;
  logic        nandRb = 1'b0;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  nandSeq dut (
    .clk(clk), .rst_n(rst_n), .softRst(softRst), .timingWord(timingWord),
    .forceCeLow(forceCeLow), .reqValid(reqValid), .reqReady(reqReady),
    .reqKind(reqKind), .reqWrite(reqWrite), .reqData(reqData),
    .rspValid(rspValid), .rspData(rspData), .devReady(devReady),
    .nandCle(nandCle), .nandAle(nandAle), .nandWeN(nandWeN), .nandReN(nandReN),
    .nandCeN(nandCeN), .nandDout(nandDout), .nandDoe(nandDoe),
    .nandDin(nandDin), .nandRb(nandRb)
  );

  typedef struct packed {
    logic [1:0]  kind;
    logic        wr;
    logic [7:0]  data;
    logic [31:0] tw;
    logic [7:0]  din;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 1'b1, 8'h70, 32'h0000_0000, 8'h00},
    '{2'd1, 1'b1, 8'h12, 32'h2314_FFFF, 8'h00},
    '{2'd2, 1'b1, 8'hA5, 32'hF0F0_0000, 8'h00},
    '{2'd2, 1'b0, 8'h00, 32'hFFFF_1532, 8'h3C},
    '{2'd3, 1'b0, 8'h00, 32'h0000_0000, 8'hC3},
    '{2'd0, 1'b0, 8'h90, 32'h1111_0000, 8'h00},
    '{2'd2, 1'b0, 8'h00, 32'h0000_FFFF, 8'h5A},
    '{2'd1, 1'b1, 8'hFF, 32'hFFFF_0000, 8'h00}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic runVec(input vec_t v);
    bit        isWr;
    bit [15:0] f;
    int        sCnt, wCnt, tCnt;
    bit        strobeLow;
    bit        sawCle, sawAle, sawDoe;
    logic [7:0] seenDout;
    isWr = (v.kind == 2'd0) || (v.kind == 2'd1) || v.wr;
    f    = isWr ? v.tw[31:16] : v.tw[15:0];
    @(negedge clk);
    check(reqReady == 1'b1, "R1", "ready before request", reqReady, 1);
    reqValid = 1'b1; reqKind = v.kind; reqWrite = v.wr;
    reqData = v.data; timingWord = v.tw;
    @(negedge clk);
    reqValid = 1'b0;
    timingWord = ~v.tw;  // R8: change right after acceptance
    sCnt = 0; wCnt = 0; tCnt = 0;
    sawCle = 1'b0; sawAle = 1'b0; sawDoe = 1'b0; seenDout = '0;
    strobeLow = isWr ? !nandWeN : !nandReN;
    while (!strobeLow && sCnt < 100) begin
      sCnt++;
      check(nandCeN == 1'b0, "R9", "CE# during setup", nandCeN, 0);
      @(negedge clk);
      strobeLow = isWr ? !nandWeN : !nandReN;
    end
    while (strobeLow && wCnt < 100) begin
      nandDin = v.din;
      if (wCnt == 0) begin
        sawCle = nandCle; sawAle = nandAle; sawDoe = nandDoe; seenDout = nandDout;
      end
      wCnt++;
      @(negedge clk);
      nandDin = ~v.din;
      strobeLow = isWr ? !nandWeN : !nandReN;
    end
    while (!reqReady && tCnt < 100) begin
      tCnt++;
      @(negedge clk);
    end
    check(sCnt == int'(f[3:0]) + 1, isWr ? "R3" : "R4", "setup length", sCnt, int'(f[3:0]) + 1);
    check(wCnt == int'(f[11:8]) + 1, isWr ? "R3" : "R4", "strobe length", wCnt, int'(f[11:8]) + 1);
    check(tCnt == int'(f[7:4]) + 1 + 2 * int'(f[15:12]), "R5", "tail length",
          tCnt, int'(f[7:4]) + 1 + 2 * int'(f[15:12]));
    check(sawCle == (v.kind == 2'd0), "R2", "CLE", sawCle, v.kind == 2'd0);
    check(sawAle == (v.kind == 2'd1), "R2", "ALE", sawAle, v.kind == 2'd1);
    check(sawDoe == isWr, "R7", "output enable", sawDoe, isWr);
    if (isWr) check(seenDout == v.data, "R7", "write byte", seenDout, v.data);
    check(rspValid == !isWr, "R6", "response pulse", rspValid, !isWr);
    if (!isWr) check(rspData == v.din, "R6", "read byte", rspData, v.din);
    @(negedge clk);
    check(rspValid == 1'b0, "R6", "pulse one cycle", rspValid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(reqReady == 1'b1, "R1", "reqReady", reqReady, 1);
    check({nandWeN, nandReN, nandCeN} == 3'b111, "R1", "strobes", {nandWeN, nandReN, nandCeN}, 7);
    check({nandCle, nandAle, rspValid} == 3'b000, "R1", "latches/rsp", {nandCle, nandAle, rspValid}, 0);

    for (int i = 0; i < NVEC; i++) runVec(VECS[i]);

    // R9 forced chip enable while idle
    forceCeLow = 1'b1;
    @(negedge clk);
    check(nandCeN == 1'b0, "R9", "forced CE# idle", nandCeN, 0);
    forceCeLow = 1'b0;
    @(negedge clk);
    check(nandCeN == 1'b1, "R9", "released CE# idle", nandCeN, 1);

    // R10 ready synchroniser latency
    nandRb = 1'b1;
    @(negedge clk);
    check(devReady == 1'b0, "R10", "after one edge", devReady, 0);
    @(negedge clk);
    check(devReady == 1'b1, "R10", "after two edges", devReady, 1);
    nandRb = 1'b0;
    @(negedge clk);
    check(devReady == 1'b1, "R10", "fall after one edge", devReady, 1);
    @(negedge clk);
    check(devReady == 1'b0, "R10", "fall after two edges", devReady, 0);

    // R11 soft reset in the middle of a read strobe
    reqValid = 1'b1; reqKind = 2'd2; reqWrite = 1'b0; timingWord = 32'h0000_0F00;
    @(negedge clk);
    reqValid = 1'b0;
    @(negedge clk);
    check(nandReN == 1'b0, "R11", "strobe active before abort", nandReN, 0);
    softRst = 1'b1;
    @(negedge clk);
    softRst = 1'b0;
    check(reqReady == 1'b1, "R11", "idle after abort", reqReady, 1);
    check({nandWeN, nandReN, nandCeN} == 3'b111, "R11", "strobes after abort",
          {nandWeN, nandReN, nandCeN}, 7);
    check(nandDoe == 1'b0, "R11", "drive after abort", nandDoe, 0);
    check(rspValid == 1'b0, "R11", "no response", rspValid, 0);
    repeat (20) @(negedge clk);
    check(rspValid == 1'b0 && reqReady == 1'b1, "R11", "stays idle", rspValid, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule